// File: doc/BRIEF.md
# Level-Based Sleep Wake-Up Detector

This block watches a bank of external port pins and does two jobs. While the chip is running it turns a chosen edge on each pin into a sticky interrupt flag. While the chip sits in a stopped-clock state it raises a wake request. There are two such states: a deep sleep, where the oscillators are off, and a second halt, where the peripheral clocks are off. Each port has its own enable and its own polarity bit. The polarity bit selects the rising or the falling edge while running. The same bit selects the high or the low level as the wake condition while stopped.

In the run state every pin passes through a clocked synchronizer chain and then an edge detector. Once a stopped state is entered, no clock is available, so the synchronizer is skipped. The wake request is then formed combinationally from the raw pin levels. A port set for edges therefore wakes the chip by level. An enabled port that is already at its active level when the stopped state begins asserts the wake request at once, and the stopped state lasts only a moment.

On the first clock edge after the stopped state ends, the flag of every enabled port found at its active level is set. On that same edge the synchronizer and edge history are reloaded from the live pins. Stale history held over from before the stop can then never be mistaken for an edge.

Top module: `wake_level_detect`

## Requirements
- R1: While rst_n is low at a clock edge, all irq_flag bits are cleared. With neither stop input high, wake_req is 0 after reset.
- R2: With the block running, a 0-to-1 change on a pin whose irq_en bit is 1 and whose irq_rise bit is 1 sets its irq_flag bit. With the default two-stage synchronizer, the flag becomes visible after the third rising clock edge that follows the pin change, and not before.
- R3: With the block running, a 1-to-0 change on an enabled pin whose irq_rise bit is 0 sets its irq_flag bit after the third rising clock edge.
- R4: A port whose irq_en bit is 0 never sets its flag and never contributes to wake_req, whatever its pin does.
- R5: While running, an irq_clr bit high at a clock edge clears that port's flag. If a new event for the same port is detected at that same edge, the flag stays set.
- R6: While sleep_st or halt2_st is high, wake_req equals the OR, over enabled ports, of pin == 1 for ports with irq_rise = 1 and pin == 0 for ports with irq_rise = 0. It is formed without any clock edge, and both stop inputs behave alike.
- R7: If an enabled port is already at its active level when a stop input rises, wake_req is high in that same cycle.
- R8: wake_req is 0 whenever both sleep_st and halt2_st are low.
- R9: While a stop input is high, clock edges change no irq_flag bit, and irq_clr is ignored.
- R10: At the first clock edge where both stop inputs are low after at least one was high, the flag of every enabled port at its active level at that edge is set.
- R11: No edge that the synchronizer captured before the stop is reported after the wake-up. Pin history is reloaded from the live pin at the wake-up edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (treated as stopped while a stop input is high) |
| rst_n | input | 1 | Synchronous active-low reset |
| port_pin | input | NUM_PORTS | Raw external port pins |
| irq_en | input | NUM_PORTS | Per-port interrupt/wake enable |
| irq_rise | input | NUM_PORTS | Per-port polarity: 1 rising edge / high level, 0 falling edge / low level |
| sleep_st | input | 1 | Deep sleep state, oscillators stopped |
| halt2_st | input | 1 | Halt state with peripheral clocks stopped |
| irq_clr | input | NUM_PORTS | Per-port flag clear, honoured only while running |
| wake_req | output | 1 | Combinational wake request, active only in a stop state |
| irq_flag | output | NUM_PORTS | Sticky per-port interrupt flags |

## Verification
The hardest situation to reach is the stale-history case of R11. A pin change must have entered the first synchronizer stage but not the second at the moment the stop begins. The pin must then fall back during the stop, and a different port must do the waking. The stimulus raises the pin exactly one clock edge before asserting sleep, and drops it at the same instant sleep rises. This freezes a half-propagated edge inside the chain. After a falling-polarity port wakes the block, the flags are watched for several cycles to confirm that no rising flag appears.

// File: rtl/wk_pkg.sv
// Package: shared parameters and helpers for the wake-up detector.
// Assumes: polarity bit 1 means rising edge / high level, 0 falling / low.
package wk_pkg;

    // Polarity encoding of a port's irq_rise bit.
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } wk_pol_e;

    // True when a pin sits at the level its polarity calls active.
    function automatic logic at_active_level(input logic pin, input logic rise);
        return (rise == POL_RISE) ? pin : ~pin;
    endfunction

    // True when the synchronized pin shows the edge its polarity selects.
    function automatic logic edge_match(input logic now_v, input logic old_v,
                                        input logic rise);
        return (rise == POL_RISE) ? (now_v & ~old_v) : (~now_v & old_v);
    endfunction

endpackage

// File: rtl/wk_port_sync.sv
// Module: wk_port_sync
// One port's synchronizer chain plus edge-history register.
// Assumes: STAGES >= 2; run_en is low while the clock is deemed stopped,
// reload pulses for one edge when the clock restarts and loads the whole
// chain and the history from the raw pin so no stale edge survives.
module wk_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic reload,
    input  logic pin,
    input  logic rise,
    output logic edge_hit
);
    import wk_pkg::*;

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          hist_q;

    // Shift the pin through the chain, or reload everything on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            hist_q  <= 1'b0;
        end else if (reload) begin
            chain_q <= {STAGES{pin}};
            hist_q  <= pin;
        end else if (run_en) begin
            chain_q <= {chain_q[LAST-1:0], pin};
            hist_q  <= chain_q[LAST];
        end
    end

    // Report the selected edge between the chain output and its history.
    always_comb begin
        edge_hit = run_en & edge_match(chain_q[LAST], hist_q, rise);
    end

endmodule

// File: rtl/wk_level_wake.sv
// Module: wk_level_wake
// Combinational level decision: which enabled ports are at their active
// level, and the wake request gated by the stopped state.
// Assumes: no clock is available while stopped, so no register is used.
module wk_level_wake #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 stopped,
    input  logic [NUM_PORTS-1:0] pin,
    input  logic [NUM_PORTS-1:0] en,
    input  logic [NUM_PORTS-1:0] rise,
    output logic [NUM_PORTS-1:0] active_en,
    output logic                 wake
);
    import wk_pkg::*;

    // Per-port active-level match, masked by enable.
    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            active_en[i] = en[i] & at_active_level(pin[i], rise[i]);
        end
    end

    // Wake only exists in a stopped state.
    always_comb begin
        wake = stopped & (|active_en);
    end

endmodule

// File: rtl/wk_flag_bank.sv
// Module: wk_flag_bank
// Sticky per-port interrupt flags with clear; a set wins over a clear.
// Assumes: hold is high while the clock is deemed stopped, freezing flags.
module wk_flag_bank #(
    parameter int NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hold,
    input  logic [NUM_PORTS-1:0] set_vec,
    input  logic [NUM_PORTS-1:0] clr_vec,
    output logic [NUM_PORTS-1:0] flags
);
    // Update flags from set and clear requests unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (!hold) begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/wake_level_detect.sv
// Module: wake_level_detect (top)
// Port wake-up detector: synchronized edge flags while running, raw-level
// wake request while in sleep or halt2, flag capture and history reload on
// the first edge after the stop ends.
// Assumes: sleep_st/halt2_st are held high for the whole stopped period;
// clock edges seen while they are high model a stopped clock.
module wake_level_detect #(
    parameter int NUM_PORTS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_pin,
    input  logic [NUM_PORTS-1:0] irq_en,
    input  logic [NUM_PORTS-1:0] irq_rise,
    input  logic                 sleep_st,
    input  logic                 halt2_st,
    input  logic [NUM_PORTS-1:0] irq_clr,
    output logic                 wake_req,
    output logic [NUM_PORTS-1:0] irq_flag
);
    logic                 stopped;
    logic                 was_stopped_q;
    logic                 wake_edge;
    logic                 run_en;
    logic [NUM_PORTS-1:0] active_en;
    logic [NUM_PORTS-1:0] edge_hits;
    logic [NUM_PORTS-1:0] set_vec;

    // Either stop state means no clock reaches the port logic.
    always_comb begin
        stopped   = sleep_st | halt2_st;
        wake_edge = was_stopped_q & ~stopped;
        run_en    = ~stopped & ~wake_edge;
    end

    // Remember whether the previous edge was in a stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_stopped_q <= 1'b0;
        end else begin
            was_stopped_q <= stopped;
        end
    end

    // One synchronizer and edge detector per port.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            wk_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .run_en  (run_en),
                .reload  (wake_edge),
                .pin     (port_pin[p]),
                .rise    (irq_rise[p]),
                .edge_hit(edge_hits[p])
            );
        end
    endgenerate

    wk_level_wake #(.NUM_PORTS(NUM_PORTS)) u_level (
        .stopped  (stopped),
        .pin      (port_pin),
        .en       (irq_en),
        .rise     (irq_rise),
        .active_en(active_en),
        .wake     (wake_req)
    );

    // Wake edge captures level causes; otherwise enabled edges set flags.
    always_comb begin
        set_vec = wake_edge ? active_en : (edge_hits & irq_en);
    end

    wk_flag_bank #(.NUM_PORTS(NUM_PORTS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (stopped),
        .set_vec(set_vec),
        .clr_vec(irq_clr),
        .flags  (irq_flag)
    );

endmodule

// File: rtl/wake_level_detect_chk.sv
// Module: wake_level_detect_chk
// Property checker for wake_level_detect, attached by bind below.
// Assumes: the same parameter values as the instance it watches.
module wake_level_detect_chk #(
    parameter int NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] port_pin,
    input logic [NUM_PORTS-1:0] irq_en,
    input logic [NUM_PORTS-1:0] irq_rise,
    input logic                 sleep_st,
    input logic                 halt2_st,
    input logic [NUM_PORTS-1:0] irq_clr,
    input logic                 wake_req,
    input logic [NUM_PORTS-1:0] irq_flag
);
    logic                 stp;
    logic                 chk_was_q;
    logic [NUM_PORTS-1:0] lvl_ok;

    // Stop state and per-port active level seen from the ports.
    always_comb begin
        stp    = sleep_st | halt2_st;
        lvl_ok = irq_en & ~(port_pin ^ irq_rise);
    end

    // Own record of the previous edge's stop state.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_was_q <= 1'b0;
        else        chk_was_q <= stp;
    end

    AST_WAKE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !stp |-> !wake_req);                                                  // R8

    AST_LEVEL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        stp |-> (wake_req == (|lvl_ok)));                                     // R6

    AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stp |=> $stable(irq_flag));                                           // R9

    AST_WAKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stp && chk_was_q) |=> ((irq_flag & $past(lvl_ok)) == $past(lvl_ok))); // R10

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flag & ~$past(irq_flag) & ~$past(irq_en)) == '0));              // R4

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stp && !chk_was_q && (irq_clr != '0) && (irq_en == '0))
        |=> ((irq_flag & $past(irq_clr)) == '0));                             // R5

endmodule

bind wake_level_detect wake_level_detect_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_pin(port_pin),
    .irq_en  (irq_en),
    .irq_rise(irq_rise),
    .sleep_st(sleep_st),
    .halt2_st(halt2_st),
    .irq_clr (irq_clr),
    .wake_req(wake_req),
    .irq_flag(irq_flag)
);

// File: tb/wake_level_detect_test.sv
// Bench: behavioural reference compared every clock, plus directed checks.
module wake_level_detect_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pin, en, rise, clr;
    logic         sleep, halt2;
    logic         wake_req;
    logic [N-1:0] flag;

    int vecs  = 0;
    int fails = 0;
    bit done  = 0;

    // Reference state
    logic [N-1:0] m_s1, m_s2, m_prev, m_flag, m_act, m_set;
    logic         m_was;

    always #10 clk = ~clk;

    wake_level_detect #(.NUM_PORTS(N), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .port_pin(pin), .irq_en(en),
        .irq_rise(rise), .sleep_st(sleep), .halt2_st(halt2),
        .irq_clr(clr), .wake_req(wake_req), .irq_flag(flag)
    );

    // Reference model, updated from the inputs held across each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = '0; m_was = 1'b0;
        end else begin
            m_act = en & ~(pin ^ rise);
            if (sleep || halt2) begin
                // clock stopped: nothing moves
            end else if (m_was) begin
                m_flag = (m_flag & ~clr) | m_act;
                m_s1 = pin; m_s2 = pin; m_prev = pin;
            end else begin
                m_set  = en & ((rise & m_s2 & ~m_prev) | (~rise & ~m_s2 & m_prev));
                m_flag = (m_flag & ~clr) | m_set;
                m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
            end
            m_was = sleep | halt2;
        end
    end

    function automatic logic model_wake();
        return (sleep | halt2) & (|(en & ~(pin ^ rise)));
    endfunction

    task automatic check(input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    task automatic compare();
        check("R6 wake_req vs model", {7'b0, wake_req}, {7'b0, model_wake()});
        check("R2 flags vs model", flag, m_flag);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        rst_n = 0; pin = 8'h1A; en = 8'h0F; rise = 8'h05; clr = '0;
        sleep = 0; halt2 = 0;
        @(negedge clk);
        tick(3);
        rst_n = 1;
        tick(1);
        check("R1 flags after reset", flag, 8'h00);
        check("R1 wake after reset", {7'b0, wake_req}, 8'h00);
        tick(4);

        // R2: rising edge on port 0, visible after third edge
        pin[0] = 1'b1;
        tick(2);
        check("R2 flag0 not yet", {7'b0, flag[0]}, 8'h00);
        tick(1);
        check("R2 flag0 set", {7'b0, flag[0]}, 8'h01);

        // R5: clear works
        clr[0] = 1'b1; tick(1); clr[0] = 1'b0;
        check("R5 flag0 cleared", {7'b0, flag[0]}, 8'h00);

        // R3: falling edge on port 1
        pin[1] = 1'b0;
        tick(3);
        check("R3 flag1 set", {7'b0, flag[1]}, 8'h01);
        pin[1] = 1'b1; pin[0] = 1'b0; tick(4);

        // R5: set wins over simultaneous clear
        pin[2] = 1'b1; tick(2);
        clr[2] = 1'b1; tick(1); clr[2] = 1'b0;
        check("R5 set beats clear", {7'b0, flag[2]}, 8'h01);
        pin[2] = 1'b0; tick(4);

        // R4: disabled port 4 toggles, no flag
        pin[4] = 1'b0; tick(3); pin[4] = 1'b1; tick(4);
        check("R4 disabled flag4", {7'b0, flag[4]}, 8'h00);

        // Sleep with nothing active; flag2 still set
        clr = 8'hFB; tick(1); clr = '0;
        sleep = 1'b1; #1;
        check("R4 R6 no wake, inactive", {7'b0, wake_req}, 8'h00);
        tick(1);

        // R9: clear ignored while stopped
        clr = 8'hFF; tick(2); clr = '0;
        check("R9 flag2 frozen", flag, 8'h04);

        // R6: port 0 goes high while asleep
        pin[0] = 1'b1; #1;
        check("R6 level wake sleep", {7'b0, wake_req}, 8'h01);
        tick(2);
        sleep = 1'b0; #1;
        check("R8 wake low when running", {7'b0, wake_req}, 8'h00);
        tick(1);
        check("R10 flag0 captured", flag, 8'h05);
        pin[0] = 1'b0; clr = 8'hFF; tick(1); clr = '0; tick(4);

        // R7: port 3 already low as halt2 enters
        pin[3] = 1'b0; halt2 = 1'b1; #1;
        check("R7 immediate wake halt2", {7'b0, wake_req}, 8'h01);
        tick(2);
        halt2 = 1'b0; tick(1);
        check("R10 flag3 after halt2", {7'b0, flag[3]}, 8'h01);
        pin[3] = 1'b1; tick(4); clr = 8'hFF; tick(1); clr = '0; tick(2);

        // R11: half-propagated rise on port 2 frozen by sleep
        pin[2] = 1'b1; tick(1);
        pin[2] = 1'b0; sleep = 1'b1; tick(2);
        pin[1] = 1'b0; #1;
        check("R6 wake via port1", {7'b0, wake_req}, 8'h01);
        tick(1);
        sleep = 1'b0; tick(5);
        check("R11 no stale flag2", {7'b0, flag[2]}, 8'h00);
        check("R10 flag1 captured", {7'b0, flag[1]}, 8'h01);
        pin[1] = 1'b1; tick(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule